// File: doc/BRIEF.md
# Stopwatch BCD Counter with Capture

This block is a three-digit decimal stopwatch. A one-cycle tick at 1 kHz advances a count of thousandths, hundredths and tenths of a second, each digit held in BCD. A wrap of the hundredths digit raises a 10 Hz event flag and a wrap of the tenths digit raises a 1 Hz event flag. Two raw key inputs, RUN and LAP, are sampled on a 1024 Hz strobe and debounced: a press only counts again after the key has been seen released for a set number of samples. Pressing both keys on the same sample does nothing.

Software reaches the block through a small register port with a 3-bit address and 4-bit data. A LAP press asks for a snapshot, which is taken into a capture buffer on the next 1 ms tick. Software reads the digits lowest first and highest last. Reading the lowest digit while no snapshot is waiting loads the live count into the buffer, so all three reads return one consistent value. A counter reset clears the running count but leaves the buffer alone. Event flags are cleared by writing ones, and an interrupt line is the OR of the flags that are unmasked.

Top module: `stw_top`

## Requirements
- R1: While running, each tick_1k pulse adds one to a three-digit BCD count (digit 0 thousandths, digit 1 hundredths, digit 2 tenths), and 999 wraps to 000.
- R2: While stopped, ticks leave the count unchanged. Register 3 is control: write bit 0 sets run, write bit 1 = 1 resets the counter; read gives run in bit 0 and the capture-renewed bit in bit 2, with other bits 0.
- R3: A counter reset clears all digits and keeps the run state, so a reset while stopped leaves the count at 000 and stopped.
- R4: A counter reset does not alter the capture buffer.
- R5: Register 4 holds the flags. Bit 0 (10 Hz) is set when digit 1 wraps from 9 to 0. Bit 1 (1 Hz) is set when digit 2 wraps. Both are set whatever the mask.
- R6: Writing 1 to a flag bit clears it. Register 5 is the mask. irq is high exactly when some flag and its mask bit are both 1.
- R7: An accepted RUN press toggles run and sets flag bit 2. An accepted LAP press requests a capture and sets flag bit 3.
- R8: A capture requested by LAP is taken on the next tick_1k and stores the count as it was before that tick's increment. It also sets the capture-renewed bit. A later LAP before the buffer has been read replaces the snapshot at the next tick.
- R9: Reading register 0 returns buffer digit 0 if capture-renewed is set. Otherwise it returns live digit 0 and loads the whole count into the buffer. Registers 1 and 2 return buffer digits 1 and 2. Reading register 2 clears capture-renewed.
- R10: After an accepted press, a key is accepted again only after DEB_SAMPLES consecutive released samples on smp_1k. A press seen earlier is ignored.
- R11: RUN and LAP both pressed on the same smp_1k sample take no effect: run, the capture and the flags are unchanged.
- R12: After rst_n, the count, buffer, run, capture-renewed, flags and mask are 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1k | input | 1 | One-cycle 1 kHz count pulse |
| smp_1k | input | 1 | One-cycle 1024 Hz key sample strobe |
| run_key | input | 1 | Raw RUN key, 1 = pressed |
| lap_key | input | 1 | Raw LAP key, 1 = pressed |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (reads have side effects) |
| addr | input | 3 | Register address |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Read data, valid in the cycle rd_en is high |
| irq | output | 1 | OR of unmasked event flags |

## Verification
The hardest state to reach is a snapshot that is replaced before it has been read. The stimulus sends a LAP press, lets one tick take the capture, lets the count move on without reading, then sends a second LAP press and tick. Only after that does it read the digits, expecting the second value. Key debounce is reached by hand-timing the sample strobe: a second press arrives after too few released samples and must be ignored, then a press after a full run of released samples must be accepted.

// File: rtl/stw_pkg.sv
package stw_pkg;
   localparam int NDIG = 3;
   typedef logic [3:0] bcd_t;
   localparam logic [2:0] A_D0    = 3'd0;
   localparam logic [2:0] A_DTOP  = 3'(NDIG - 1);
   localparam logic [2:0] A_CTRL  = 3'(NDIG);
   localparam logic [2:0] A_FLAGS = 3'(NDIG + 1);
   localparam logic [2:0] A_MASK  = 3'(NDIG + 2);
   localparam int F_10HZ = 0;
   localparam int F_1HZ  = 1;
   localparam int F_RUN  = 2;
   localparam int F_LAP  = 3;
endpackage

// File: rtl/stw_bcd_digit.sv
module stw_bcd_digit
   import stw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output bcd_t q,
   output logic wrap
);
   assign wrap = inc && (q == 4'd9);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (clr)    q <= '0;
      else if (inc)    q <= (q == 4'd9) ? 4'd0 : q + 4'd1;
   end
endmodule

// File: rtl/stw_keydeb.sv
module stw_keydeb #(
   parameter int DEB_SAMPLES = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp,
   input  logic key,
   output logic evt
);
   localparam int CW = $clog2(DEB_SAMPLES) + 1;

   logic          armed;
   logic [CW-1:0] lowcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed  <= 1'b1;
         lowcnt <= '0;
         evt    <= 1'b0;
      end else begin
         evt <= 1'b0;
         if (smp) begin
            if (armed) begin
               if (key) begin
                  evt    <= 1'b1;
                  armed  <= 1'b0;
                  lowcnt <= '0;
               end
            end else if (key) begin
               lowcnt <= '0;
            end else if (lowcnt == CW'(DEB_SAMPLES - 1)) begin
               armed  <= 1'b1;
               lowcnt <= '0;
            end else begin
               lowcnt <= lowcnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/stw_top.sv
module stw_top
   import stw_pkg::*;
#(
   parameter int DEB_SAMPLES = 48
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_1k,
   input  logic       smp_1k,
   input  logic       run_key,
   input  logic       lap_key,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [2:0] addr,
   input  logic [3:0] wdata,
   output logic [3:0] rdata,
   output logic       irq
);
   generate
      if (DEB_SAMPLES < 2) begin : g_bad_deb
         $error("DEB_SAMPLES must be at least 2");
      end
      if (NDIG != 3) begin : g_bad_ndig
         $error("stopwatch expects three digits");
      end
   endgenerate

   logic [NDIG-1:0][3:0] cnt;
   logic [NDIG-1:0][3:0] cap_buf;
   logic [NDIG-1:0]      inc;
   logic [NDIG-1:0]      wrap;
   logic                 run, crnw, lap_pend;
   logic [3:0]           flags, mask, set_vec, clr_vec;
   logic                 run_evt, lap_evt, run_ok, lap_ok;
   logic                 wr_ctrl, clr_cnt, cap, rd_low, rd_top;

   assign wr_ctrl = wr_en && (addr == A_CTRL);
   assign clr_cnt = wr_ctrl && wdata[1];
   assign cap     = tick_1k && lap_pend;
   assign rd_low  = rd_en && (addr == A_D0);
   assign rd_top  = rd_en && (addr == A_DTOP);

   // digit chain
   generate
      for (genvar i = 0; i < NDIG; i++) begin : g_dig
         if (i == 0) begin : g_first
            assign inc[i] = run && tick_1k;
         end else begin : g_next
            assign inc[i] = wrap[i-1];
         end
         stw_bcd_digit i_digit (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr_cnt),
            .inc  (inc[i]),
            .q    (cnt[i]),
            .wrap (wrap[i])
         );
      end
   endgenerate

   stw_keydeb #(.DEB_SAMPLES(DEB_SAMPLES)) i_deb_run (
      .clk(clk), .rst_n(rst_n), .smp(smp_1k), .key(run_key), .evt(run_evt)
   );
   stw_keydeb #(.DEB_SAMPLES(DEB_SAMPLES)) i_deb_lap (
      .clk(clk), .rst_n(rst_n), .smp(smp_1k), .key(lap_key), .evt(lap_evt)
   );

   assign run_ok = run_evt && !lap_evt;
   assign lap_ok = lap_evt && !run_evt;

   always_comb begin
      set_vec         = '0;
      set_vec[F_10HZ] = wrap[1] && !clr_cnt;
      set_vec[F_1HZ]  = wrap[2] && !clr_cnt;
      set_vec[F_RUN]  = run_ok;
      set_vec[F_LAP]  = lap_ok;
      clr_vec         = (wr_en && (addr == A_FLAGS)) ? wdata : 4'h0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run      <= 1'b0;
         crnw     <= 1'b0;
         lap_pend <= 1'b0;
         flags    <= '0;
         mask     <= '0;
         cap_buf  <= '0;
      end else begin
         if (wr_ctrl)     run <= wdata[0];
         else if (run_ok) run <= !run;

         if (lap_ok)   lap_pend <= 1'b1;
         else if (cap) lap_pend <= 1'b0;

         if (cap)                 cap_buf <= cnt;
         else if (rd_low && !crnw) cap_buf <= cnt;

         if (cap)         crnw <= 1'b1;
         else if (rd_top) crnw <= 1'b0;

         flags <= (flags & ~clr_vec) | set_vec;
         if (wr_en && (addr == A_MASK)) mask <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (addr == A_D0)         rdata = crnw ? cap_buf[0] : cnt[0];
         else if (addr == A_CTRL)  rdata = {1'b0, crnw, 1'b0, run};
         else if (addr == A_FLAGS) rdata = flags;
         else if (addr == A_MASK)  rdata = mask;
         else begin
            for (int i = 1; i < NDIG; i++)
               if (addr == 3'(i)) rdata = cap_buf[i];
         end
      end
   end

   assign irq = |(flags & mask);
endmodule

// File: rtl/stw_checker.sv
module stw_checker
   import stw_pkg::*;
(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tick_1k,
   input logic                 wr_en,
   input logic [2:0]           addr,
   input logic [3:0]           wdata,
   input logic [NDIG-1:0][3:0] cnt,
   input logic [NDIG-1:0][3:0] cap_buf,
   input logic                 run,
   input logic                 crnw,
   input logic                 lap_pend,
   input logic                 run_evt,
   input logic                 lap_evt
);
   // R1
   a_r1_digits_bcd: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[0] <= 4'd9) && (cnt[1] <= 4'd9) && (cnt[2] <= 4'd9));

   // R2
   a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !(wr_en && addr == A_CTRL)) |=> $stable(cnt));

   // R3
   a_r3_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CTRL && wdata[1]) |=> (cnt == '0));

   // R4
   a_r4_reset_keeps_buf: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CTRL && wdata[1] && !(tick_1k && lap_pend)
       && !(addr == A_D0)) |=> $stable(cap_buf));

   // R8
   a_r8_capture_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1k && lap_pend) |=> (crnw && (cap_buf == $past(cnt))));

   // R11
   a_r11_both_keys_void: assert property (@(posedge clk) disable iff (!rst_n)
      (run_evt && lap_evt && !(wr_en && addr == A_CTRL)) |=> $stable(run));
endmodule

bind stw_top stw_checker i_stw_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick_1k (tick_1k),
   .wr_en   (wr_en),
   .addr    (addr),
   .wdata   (wdata),
   .cnt     (cnt),
   .cap_buf (cap_buf),
   .run     (run),
   .crnw    (crnw),
   .lap_pend(lap_pend),
   .run_evt (run_evt),
   .lap_evt (lap_evt)
);

// File: tb/test_stw_top.sv
module test_stw_top;
   localparam int DEB = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1k = 1'b0, smp_1k = 1'b0, run_key = 1'b0, lap_key = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0] addr = '0;
   logic [3:0] wdata = '0;
   logic [3:0] rdata;
   logic       irq;
   int         checks = 0, fails = 0;

   always #4 clk = ~clk;

   stw_top #(.DEB_SAMPLES(DEB)) i_stw_top (
      .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .smp_1k(smp_1k),
      .run_key(run_key), .lap_key(lap_key), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   localparam int          NV = 7;
   localparam int          VT [NV] = '{0, 9, 99, 100, 999, 1000, 1234};
   localparam logic [11:0] VD [NV] = '{12'h000, 12'h009, 12'h099, 12'h100,
                                       12'h999, 12'h000, 12'h234};
   localparam logic [3:0]  VF [NV] = '{4'h0, 4'h0, 4'h0, 4'h1, 4'h1, 4'h3, 4'h3};

   task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [3:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [3:0] d);
      @(negedge clk); rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_1k = 1'b1;
         @(negedge clk); tick_1k = 1'b0;
      end
   endtask

   task automatic pulse(input logic r, input logic l);
      @(negedge clk); run_key = r; lap_key = l; smp_1k = 1'b1;
      @(negedge clk); smp_1k = 1'b0; run_key = 1'b0; lap_key = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic press(input logic r, input logic l);
      pulse(r, l);
      for (int i = 0; i < DEB; i++) pulse(1'b0, 1'b0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [3:0] v, d0, d1, d2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state
      rd(3'd3, v); chk("R12 ctrl", v, 4'h0);
      rd(3'd4, v); chk("R12 flags", v, 4'h0);
      rd(3'd5, v); chk("R12 mask", v, 4'h0);
      #1 chk("R12 irq", {3'b0, irq}, 4'h0);
      rd(3'd0, d0); rd(3'd1, d1); rd(3'd2, d2);
      chk("R12 count", {d2[0], d1, d0}, 4'h0);

      // R2 stopped: ticks ignored
      ticks(7);
      rd(3'd0, d0); chk("R2 stopped d0", d0, 4'h0);

      // R1/R5 vector table
      for (int k = 0; k < NV; k++) begin
         wr(3'd3, 4'b0011);
         wr(3'd4, 4'hF);
         ticks(VT[k]);
         wr(3'd3, 4'b0000);
         rd(3'd0, d0); rd(3'd1, d1); rd(3'd2, d2);
         chk("R1 d0", d0, VD[k][3:0]);
         chk("R1 d1", d1, VD[k][7:4]);
         chk("R1 d2", d2, VD[k][11:8]);
         rd(3'd4, v); chk("R5 flags", v & 4'h3, VF[k]);
      end

      // R3 reset while stopped
      wr(3'd3, 4'b0010);
      ticks(3);
      rd(3'd0, d0); chk("R3 count zero", d0, 4'h0);
      rd(3'd3, v);  chk("R3 still stopped", v, 4'h0);

      // R7 run key toggles, sets flag bit 2
      wr(3'd4, 4'hF);
      press(1'b1, 1'b0);
      rd(3'd3, v); chk("R7 run on", v, 4'h1);
      rd(3'd4, v); chk("R7 run flag", v, 4'h4);

      // R10 debounce
      pulse(1'b1, 1'b0);
      rd(3'd3, v); chk("R10 first press toggles", v, 4'h0);
      pulse(1'b0, 1'b0); pulse(1'b0, 1'b0);
      pulse(1'b1, 1'b0);
      rd(3'd3, v); chk("R10 early press ignored", v, 4'h0);
      for (int i = 0; i < DEB; i++) pulse(1'b0, 1'b0);
      pulse(1'b1, 1'b0);
      rd(3'd3, v); chk("R10 rearmed press", v, 4'h1);
      for (int i = 0; i < DEB; i++) pulse(1'b0, 1'b0);

      // R11 simultaneous keys
      wr(3'd4, 4'hF);
      press(1'b1, 1'b1);
      ticks(1);
      rd(3'd3, v); chk("R11 run unchanged", v, 4'h1);
      rd(3'd4, v); chk("R11 no flags", v, 4'h0);

      // R8/R9 capture and read order
      wr(3'd3, 4'b0011);
      ticks(37);
      press(1'b0, 1'b1);
      ticks(1);
      rd(3'd3, v); chk("R8 renewed set", v, 4'h5);
      ticks(5);
      rd(3'd0, d0); chk("R9 d0 from buffer", d0, 4'h7);
      rd(3'd1, d1); chk("R9 d1 from buffer", d1, 4'h3);
      rd(3'd2, d2); chk("R9 d2 from buffer", d2, 4'h0);
      rd(3'd3, v);  chk("R9 renewed cleared", v, 4'h1);
      rd(3'd4, v);  chk("R7 lap flag", v & 4'h8, 4'h8);

      // R4 reset keeps buffer
      press(1'b0, 1'b1);
      ticks(1);
      wr(3'd3, 4'b0011);
      rd(3'd0, d0); chk("R4 buffer d0 kept", d0, 4'h3);
      rd(3'd1, d1); chk("R4 buffer d1 kept", d1, 4'h4);
      rd(3'd2, d2);
      wr(3'd3, 4'b0000);
      rd(3'd0, d0); chk("R3 live count after reset", d0, 4'h0);

      // R8 replace pending snapshot
      wr(3'd3, 4'b0011);
      ticks(5);
      press(1'b0, 1'b1);
      ticks(1);
      ticks(10);
      press(1'b0, 1'b1);
      ticks(1);
      wr(3'd3, 4'b0000);
      rd(3'd0, d0); chk("R8 replaced d0", d0, 4'h6);
      rd(3'd1, d1); chk("R8 replaced d1", d1, 4'h1);
      rd(3'd2, d2);

      // R6 mask, irq, write-1-clear
      wr(3'd4, 4'hF);
      wr(3'd5, 4'h0);
      wr(3'd3, 4'b0011);
      ticks(100);
      wr(3'd3, 4'b0000);
      #1 chk("R6 masked irq low", {3'b0, irq}, 4'h0);
      rd(3'd4, v); chk("R5 set while masked", v, 4'h1);
      wr(3'd5, 4'h1);
      #1 chk("R6 irq high", {3'b0, irq}, 4'h1);
      wr(3'd4, 4'h1);
      #1 chk("R6 irq after clear", {3'b0, irq}, 4'h0);
      rd(3'd4, v); chk("R6 flag cleared", v, 4'h0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule